// File: doc/BRIEF.md
# Integer ALU with Carry, Overflow and Condition Flags

This block is a 32-bit integer execution unit with its own flag state. Each cycle that the valid strobe is high it takes two operands and an operation code. It computes one of add, add-with-carry, AND, OR, XOR or NOT. On the same clock edge it registers the result and updates a 3-bit fixed-point exception register holding carry, overflow and sticky summary-overflow.

Three per-instruction enables choose which state is written:
- the carry enable controls the carry flag;
- the overflow enable controls the overflow and summary-overflow flags;
- the record enable controls condition field 0 of a 32-bit condition register.

When condition field 0 is written, it is loaded with a one-hot sign classification of the result, together with a copy of the summary-overflow flag. A carry-in select adds one to a plain add. The add-with-carry operation takes its extra carry-in from the stored carry flag instead.

Top module: `int_alu_flags`

## Requirements
- R1: Operation code 0 (plain add) registers `a + b + cin_sel_i` modulo 2^32 as the result.
- R2: Operation code 1 (add-with-carry) registers `a + b + CA` modulo 2^32, where CA is the stored carry flag before the operation. `cin_sel_i` has no effect on this operation.
- R3: The carry-out of an add is bit 32 of the zero-extended sum. It is written to CA (`xer_o` bit 0) only when `ca_en_i` is high. Otherwise CA keeps its value.
- R4: Overflow is flagged when bits 32 and 31 of the sign-extended sum differ. The flags change as follows:
  - `ov_en_i` high, overflow: OV (`xer_o` bit 1) and SO (`xer_o` bit 2) are both set.
  - `ov_en_i` high, no overflow: OV is cleared and SO is unchanged.
  - `ov_en_i` low: OV and SO are both unchanged.
- R5: Once set, SO stays set until reset.
- R6: Operation codes 2, 3, 4 and 5 register the values below:

  | Code | Result |
  |------|--------|
  | 2 | `a & b` |
  | 3 | `a \| b` |
  | 4 | `a ^ b` |
  | 5 | `~a` |

  These operations carry out 0 and never overflow. With the matching enables set, they clear CA and clear OV.
- R7: When `rec_en_i` is high, `cr_o[31:28]` (field 0; bit 0 counted from the MSB) receives {LT, GT, EQ, SO}:
  - LT is set when the result is negative as a signed number.
  - GT is set when the result is positive as a signed number.
  - EQ is set when the result is zero.
  - SO is the flag's value after this operation's update.

  Other fields are never written. With `rec_en_i` low the condition register is unchanged.
- R8: While `valid_i` is low, `result_o`, `xer_o` and `cr_o` are unchanged.
- R9: A synchronous reset clears `result_o`, `xer_o` and `cr_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Execute this cycle's operation |
| op_i | input | 3 | Operation code (0 add, 1 add-with-carry, 2 AND, 3 OR, 4 XOR, 5 NOT) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| ca_en_i | input | 1 | Write the carry flag |
| ov_en_i | input | 1 | Write overflow and summary overflow |
| rec_en_i | input | 1 | Write condition field 0 |
| cin_sel_i | input | 1 | Carry-in of one for a plain add |
| result_o | output | 32 | Registered result |
| xer_o | output | 3 | Exception flags {SO, OV, CA} |
| cr_o | output | 32 | Condition register |

## Verification
A wrong carry flag is visible at `xer_o` one cycle after the operation that set it. It shows a second time, in the result of a later add-with-carry. A summary-overflow bit that is cleared when it should not be appears at once in `xer_o`. It also appears in bit 28 of `cr_o` at the next record-enabled operation. An error in the sign classification appears in `cr_o[31:29]` on the cycle after the operation. The directed cases aim to expose each of these within one or two operations.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADDC = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_NOT  = 3'd5
   } alu_op_e;

   localparam int XER_CA = 0;
   localparam int XER_OV = 1;
   localparam int XER_SO = 2;
   localparam int XER_W  = 3;
   localparam int CR_FIELD_W = 4;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int CARRY_STYLE = 0
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             ca_i,
   input  logic             cin_sel_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o,
   output logic             ovf_o
);
   logic             cin;
   logic             is_logic;
   logic [WIDTH-1:0] sum;
   logic             add_cout;
   logic             add_ovf;

   assign cin      = (op_i == OP_ADDC) ? ca_i : cin_sel_i;
   assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) ||
                     (op_i == OP_XOR) || (op_i == OP_NOT);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_datapath: WIDTH must be at least 2");
   end
   if (CARRY_STYLE != 0 && CARRY_STYLE != 1) begin : g_bad_style
      $error("alu_datapath: CARRY_STYLE must be 0 or 1");
   end

   if (CARRY_STYLE == 0) begin : g_wide
      logic [WIDTH:0] zsum;
      logic [WIDTH:0] ssum;
      assign zsum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin};
      assign ssum = {a_i[WIDTH-1], a_i} + {b_i[WIDTH-1], b_i}
                    + {{WIDTH{1'b0}}, cin};
      assign sum      = zsum[WIDTH-1:0];
      assign add_cout = zsum[WIDTH];
      assign add_ovf  = ssum[WIDTH] ^ ssum[WIDTH-1];
   end else begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]  = a_i[i] ^ b_i[i] ^ c[i];
         assign c[i+1]  = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & c[i]);
      end
      assign add_cout = c[WIDTH];
      assign add_ovf  = c[WIDTH] ^ c[WIDTH-1];
   end

   always_comb begin
      unique case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_NOT:  res_o = ~a_i;
         default: res_o = sum;
      endcase
   end

   assign cout_o = !is_logic && add_cout;
   assign ovf_o  = !is_logic && add_ovf;
endmodule

// File: rtl/alu_xer_update.sv
module alu_xer_update
   import alu_pkg::*;
(
   input  logic [XER_W-1:0] xer_q_i,
   input  logic             ca_en_i,
   input  logic             ov_en_i,
   input  logic             cout_i,
   input  logic             ovf_i,
   output logic [XER_W-1:0] xer_d_o
);
   always_comb begin
      xer_d_o = xer_q_i;
      if (ca_en_i) begin
         xer_d_o[XER_CA] = cout_i;
      end
      if (ov_en_i) begin
         if (ovf_i) begin
            xer_d_o[XER_OV] = 1'b1;
            xer_d_o[XER_SO] = 1'b1;
         end else begin
            xer_d_o[XER_OV] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/alu_cr_update.sv
module alu_cr_update
   import alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int CR_FIELDS = 8,
   localparam int CRW      = CR_FIELDS * CR_FIELD_W
) (
   input  logic [CRW-1:0]   cr_q_i,
   input  logic [WIDTH-1:0] res_i,
   input  logic             so_i,
   input  logic             rec_en_i,
   output logic [CRW-1:0]   cr_d_o
);
   logic neg, zero, pos;
   assign neg  = res_i[WIDTH-1];
   assign zero = (res_i == '0);
   assign pos  = !neg && !zero;

   if (CR_FIELDS < 1) begin : g_bad_fields
      $error("alu_cr_update: CR_FIELDS must be at least 1");
   end

   for (genvar f = 0; f < CR_FIELDS; f++) begin : g_field
      localparam int HI = CRW - 1 - f * CR_FIELD_W;
      if (f == 0) begin : g_rec
         assign cr_d_o[HI -: CR_FIELD_W] = rec_en_i ? {neg, pos, zero, so_i}
                                                    : cr_q_i[HI -: CR_FIELD_W];
      end else begin : g_keep
         assign cr_d_o[HI -: CR_FIELD_W] = cr_q_i[HI -: CR_FIELD_W];
      end
   end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int CR_FIELDS   = 8,
   parameter int CARRY_STYLE = 0,
   localparam int CRW        = CR_FIELDS * CR_FIELD_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid_i,
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             ca_en_i,
   input  logic             ov_en_i,
   input  logic             rec_en_i,
   input  logic             cin_sel_i,
   output logic [WIDTH-1:0] result_o,
   output logic [XER_W-1:0] xer_o,
   output logic [CRW-1:0]   cr_o
);
   logic [WIDTH-1:0] res_q, res_d;
   logic [XER_W-1:0] xer_q, xer_d;
   logic [CRW-1:0]   cr_q, cr_d;
   logic             cout, ovf;

   alu_datapath #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) u_dp (
      .op_i      (alu_op_e'(op_i)),
      .a_i       (a_i),
      .b_i       (b_i),
      .ca_i      (xer_q[XER_CA]),
      .cin_sel_i (cin_sel_i),
      .res_o     (res_d),
      .cout_o    (cout),
      .ovf_o     (ovf)
   );

   alu_xer_update u_xer (
      .xer_q_i (xer_q),
      .ca_en_i (ca_en_i),
      .ov_en_i (ov_en_i),
      .cout_i  (cout),
      .ovf_i   (ovf),
      .xer_d_o (xer_d)
   );

   alu_cr_update #(.WIDTH(WIDTH), .CR_FIELDS(CR_FIELDS)) u_cr (
      .cr_q_i   (cr_q),
      .res_i    (res_d),
      .so_i     (xer_d[XER_SO]),
      .rec_en_i (rec_en_i),
      .cr_d_o   (cr_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         xer_q <= '0;
         cr_q  <= '0;
      end else if (valid_i) begin
         res_q <= res_d;
         xer_q <= xer_d;
         cr_q  <= cr_d;
      end
   end

   assign result_o = res_q;
   assign xer_o    = xer_q;
   assign cr_o     = cr_q;

   // R3: carry flag holds when its enable is low
   a_r3_ca_hold: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !ca_en_i) |=> $stable(xer_q[XER_CA]));

   // R4: detected overflow under enable sets OV and SO
   a_r4_ov_sets: assert property (@(posedge clk) disable iff (rst)
      (valid_i && ov_en_i && ovf) |=> (xer_q[XER_OV] && xer_q[XER_SO]));

   // R4: no overflow under enable clears OV, SO unchanged
   a_r4_ov_clear: assert property (@(posedge clk) disable iff (rst)
      (valid_i && ov_en_i && !ovf) |=>
         (!xer_q[XER_OV] && $stable(xer_q[XER_SO])));

   // R5: summary overflow is sticky
   a_r5_so_sticky: assert property (@(posedge clk) disable iff (rst)
      xer_q[XER_SO] |=> xer_q[XER_SO]);

   // R7: recorded field is one-hot and mirrors SO
   a_r7_cr_onehot: assert property (@(posedge clk) disable iff (rst)
      (valid_i && rec_en_i) |=>
         (($countones(cr_q[CRW-1 -: 3]) == 1) &&
          (cr_q[CRW-4] == xer_q[XER_SO])));

   // R8: idle cycles leave all state untouched
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(res_q) && $stable(xer_q) && $stable(cr_q)));

   // R9: reset clears flags and condition register
   a_r9_reset_clear: assert property (@(posedge clk)
      rst |=> ((xer_q == '0) && (cr_q == '0) && (res_q == '0)));
endmodule

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] a = 32'd0, b = 32'd0;
   logic        ca_en = 1'b0, ov_en = 1'b0, rec_en = 1'b0, cin_sel = 1'b0;
   logic [31:0] res;
   logic [2:0]  xer;
   logic [31:0] cr;

   int checks = 0;
   int errors = 0;

   logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;
   logic [31:0] m_res = 32'd0, m_cr = 32'd0;

   always #2 clk = ~clk;

   int_alu_flags u0 (
      .clk(clk), .rst(rst), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
      .ca_en_i(ca_en), .ov_en_i(ov_en), .rec_en_i(rec_en), .cin_sel_i(cin_sel),
      .result_o(res), .xer_o(xer), .cr_o(cr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      chk(req, "result", res, m_res);
      chk(req, "xer", {29'd0, xer}, {29'd0, m_so, m_ov, m_ca});
      chk(req, "cr", cr, m_cr);
   endtask

   task automatic issue(input logic v, input logic [2:0] o,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic ce, input logic oe, input logic re,
                        input logic cs, input string req);
      logic [63:0] zs, ss;
      logic        cin, cy, ov, lg;
      logic [31:0] r;
      valid = v; op = o; a = x; b = y;
      ca_en = ce; ov_en = oe; rec_en = re; cin_sel = cs;
      cin = (o == 3'd1) ? m_ca : cs;
      zs  = {32'd0, x} + {32'd0, y} + {63'd0, cin};
      ss  = {{32{x[31]}}, x} + {{32{y[31]}}, y} + {63'd0, cin};
      lg  = (o >= 3'd2) && (o <= 3'd5);
      case (o)
         3'd2:    r = x & y;
         3'd3:    r = x | y;
         3'd4:    r = x ^ y;
         3'd5:    r = ~x;
         default: r = zs[31:0];
      endcase
      cy = lg ? 1'b0 : zs[32];
      ov = lg ? 1'b0 : (ss[32] ^ ss[31]);
      if (v) begin
         m_res = r;
         if (ce) m_ca = cy;
         if (oe) begin
            if (ov) begin m_ov = 1'b1; m_so = 1'b1; end
            else m_ov = 1'b0;
         end
         if (re) m_cr[31:28] = {r[31], !r[31] && (r != 0), r == 0, m_so};
      end
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
      compare_all(req);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_ca = 0; m_ov = 0; m_so = 0; m_res = 0; m_cr = 0;
      compare_all("R9");
   endtask

   task automatic t_add_basic;
      issue(1, 3'd0, 32'd5, 32'd7, 1, 1, 1, 0, "R1");
      issue(1, 3'd0, 32'd5, 32'd7, 1, 1, 1, 1, "R1");
      issue(1, 3'd0, 32'hFFFF_FFF0, 32'd3, 1, 1, 1, 0, "R7");
   endtask

   task automatic t_unsigned_edge;
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'd1, 1, 1, 1, 0, "R3");
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'd0, 1, 1, 1, 1, "R3");
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'd1, 1, 1, 1, 1, "R3");
      issue(1, 3'd0, 32'd1, 32'd1, 1, 0, 0, 0, "R3");
   endtask

   task automatic t_gating;
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'd2, 1, 0, 0, 0, "R3");
      issue(1, 3'd0, 32'd1, 32'd1, 0, 0, 0, 0, "R3");
      issue(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, 1, 0, "R4");
   endtask

   task automatic t_signed_edge;
      issue(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 1, 1, 1, 0, "R4");
      issue(1, 3'd0, 32'd3, 32'd4, 1, 1, 1, 0, "R4");
      issue(1, 3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 1, 0, "R4");
      issue(1, 3'd0, 32'h7FFF_FFFF, 32'd0, 1, 1, 1, 1, "R4");
      issue(1, 3'd0, 32'd0, 32'd0, 1, 1, 1, 0, "R5");
   endtask

   task automatic t_addc;
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'd1, 1, 1, 0, 0, "R2");
      issue(1, 3'd1, 32'd10, 32'd20, 1, 1, 1, 0, "R2");
      issue(1, 3'd1, 32'd10, 32'd20, 1, 1, 1, 1, "R2");
      issue(1, 3'd1, 32'hFFFF_FFFF, 32'd0, 1, 1, 1, 1, "R2");
      issue(1, 3'd1, 32'h7FFF_FFFF, 32'd0, 1, 1, 1, 0, "R2");
   endtask

   task automatic t_logic;
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0, "R6");
      issue(1, 3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 1, 1, 1, "R6");
      issue(1, 3'd3, 32'h8000_0000, 32'h0000_0001, 1, 1, 1, 0, "R6");
      issue(1, 3'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1, 1, 1, 0, "R6");
      issue(1, 3'd5, 32'h8000_0000, 32'd0, 1, 1, 1, 0, "R6");
   endtask

   task automatic t_idle;
      issue(1, 3'd0, 32'hFFFF_FFFF, 32'd5, 1, 1, 1, 0, "R8");
      issue(0, 3'd0, 32'h7FFF_FFFF, 32'd1, 1, 1, 1, 1, "R8");
      issue(0, 3'd5, 32'd0, 32'd0, 1, 1, 1, 0, "R8");
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      compare_all("R9");
      t_add_basic();
      t_unsigned_edge();
      t_gating();
      t_signed_edge();
      t_addc();
      t_logic();
      t_idle();
      t_reset();
      issue(1, 3'd0, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, 0, "R4");
      t_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule